// File: doc/BRIEF.md
# Critical-Word-First Line Refill Controller

This block resolves read misses for a direct-mapped, write-through cache whose backing store returns one word per bus transfer. On a miss it sends a single request to memory. The request carries the line number and the word offset at which the transfer should begin. In the default ordering the transfer begins at the word the processor asked for and wraps past the end of the line. That word is handed to the processor the moment it arrives. The rest of the line lands in the cache array while the processor continues.

A second ordering can be selected with the `wrap_mode` input. In that ordering the transfer starts at word zero and the processor stays stalled until the whole line is in place. Under either ordering the cache array has a single port, and an arriving refill word always takes that port. A processor lookup that wants the port in the same cycle waits.

The line being filled stays invalid until its final word is written. During the fill, a per-word bitmap allows hits on words that have already landed. Any miss raised while a fill is running is held until that fill ends. A replaced line is overwritten and never written back.

Top module: `crit_refill`

## Requirements
- R1: After reset `cpu_ack` and `mem_req` are 0 and every line is invalid, so the first read of any address causes a memory request.
- R2: A read that hits a valid line with a matching tag, presented while no refill word arrives, is acknowledged on the next clock edge with the stored word and raises no `mem_req`.
- R3: A miss raises `mem_req` for exactly one cycle, one edge after the miss is seen. With it, `mem_line` carries the address bits above the word offset, and `mem_off` carries the requested word's offset (`wrap_mode`=1) or 0 (`wrap_mode`=0).
- R4: With `wrap_mode`=1, the k-th returned word (k from 0) is stored at offset (start + k) mod LINE_WORDS. The missing read is acknowledged, with the returned word as data, on the same edge that accepts the first returned word.
- R5: With `wrap_mode`=0, the missing read is acknowledged on the edge that accepts the LINE_WORDS-th returned word, with the requested word as data.
- R6: On any edge where `mem_valid` is high, the refill write takes the cache array. No hit can be acknowledged from that edge.
- R7: During a fill, a read of the filling line is answered from the cache if its word has already been written. Otherwise it waits until that word is written, and it never causes a second request.
- R8: A miss raised while a refill is in progress sends its `mem_req` only after the last word of the current refill has been accepted.
- R9: After its last word is written, a filled line is valid with its new tag, and later reads of it hit. A line evicted by a conflicting line in the same set is simply overwritten, and reading it again misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wrap_mode | input | 1 | 1: critical word first with early release; 0: line order, release after the full line |
| cpu_req | input | 1 | Read request; held with a stable address until `cpu_ack` |
| cpu_addr | input | ADDR_W | Word address of the read |
| cpu_ack | output | 1 | One-cycle pulse; `cpu_rdata` is valid |
| cpu_rdata | output | DATA_W | Read data |
| mem_req | output | 1 | One-cycle line fetch request |
| mem_line | output | ADDR_W-log2(LINE_WORDS) | Line number of the fetch |
| mem_off | output | log2(LINE_WORDS) | Word offset at which the fetch starts |
| mem_valid | input | 1 | A returned word is present this cycle |
| mem_rdata | input | DATA_W | Returned word |

## Verification
A quiet hit is due one edge after the request is presented, so its acknowledge shows up at the first sample. A miss's `mem_req` is due one edge after the miss is seen. The acknowledge of a miss is due on the edge that accepts the first returned word (wrap ordering) or the last returned word (line ordering).

The bench samples 1 ns after each falling edge. It counts the returned words the design has accepted, instead of counting absolute cycles, so every acknowledge is checked against the number of beats consumed for the current fill. Hits are also checked to follow an edge on which no refill word was present. A fill with idle gaps between beats exposes the window in which already-written words of the filling line may hit.

// File: rtl/crit_refill_pkg.sv
package crit_refill_pkg;

  // Offset of the k-th word of a fill that begins at 'start'; words is a power of two.
  function automatic int unsigned slot_at(int unsigned start, int unsigned k,
                                          int unsigned words);
    return (start + k) & (words - 1);
  endfunction

  // True when beat index k is the final beat of a line of 'words' words.
  function automatic bit last_k(int unsigned k, int unsigned words);
    return k == words - 1;
  endfunction

endpackage

// File: rtl/refill_seq.sv
module refill_seq
  import crit_refill_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [OFF_W-1:0]      start_off,
  input  logic                  word_in,
  output logic                  active,
  output logic                  beat,
  output logic [OFF_W-1:0]      slot,
  output logic                  first_beat,
  output logic                  last_beat,
  output logic [LINE_WORDS-1:0] filled
);

  logic [OFF_W-1:0] base_q, cnt_q;

  assign beat       = word_in && active;
  assign slot       = OFF_W'(slot_at(32'(base_q), 32'(cnt_q), LINE_WORDS));
  assign first_beat = beat && (cnt_q == '0);
  assign last_beat  = beat && last_k(32'(cnt_q), LINE_WORDS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      base_q <= start_off;
      cnt_q  <= '0;
    end else if (beat) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_beat) active <= 1'b0;
    end
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_fill_bit
    always_ff @(posedge clk) begin
      if (!rst_n || start) filled[w] <= 1'b0;
      else if (beat && slot == OFF_W'(w)) filled[w] <= 1'b1;
    end
  end

  // R4: memory only returns words while a fill is open
  p_beat_in_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_in |-> active);

  // R7: when a fill closes every word of the line has been marked written
  p_all_filled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (&filled));

endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int SETS       = 8,
  parameter int LINE_WORDS = 4,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 5,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              set_en,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  set_tag
);

  logic [DATA_W-1:0] words_q [SETS*LINE_WORDS];
  logic [TAG_W-1:0]  tag_q   [SETS];
  logic [SETS-1:0]   valid_q;

  assign rd_data  = words_q[{rd_idx, rd_off}];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) words_q[{wr_idx, wr_off}] <= wr_data;
    if (set_en) tag_q[set_idx] <= set_tag;
  end

  for (genvar s = 0; s < SETS; s++) begin : g_valid
    always_ff @(posedge clk) begin
      if (!rst_n) valid_q[s] <= 1'b0;
      else if (clr_en && clr_idx == IDX_W'(s)) valid_q[s] <= 1'b0;
      else if (set_en && set_idx == IDX_W'(s)) valid_q[s] <= 1'b1;
    end
  end

endmodule

// File: rtl/crit_refill.sv
module crit_refill
  import crit_refill_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 8,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap_mode,
  input  logic              cpu_req,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ack,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic [LINE_W-1:0] mem_line,
  output logic [OFF_W-1:0]  mem_off,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata
);

  // address split
  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_off = cpu_addr[OFF_W-1:0];
  assign req_idx = cpu_addr[OFF_W +: IDX_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // fill context
  logic             waiting;
  logic             fill_wrap;
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;

  // named internal events
  logic                  fill_active, beat, first_beat, last_beat;
  logic [OFF_W-1:0]      slot, start_off;
  logic [LINE_WORDS-1:0] filled;
  logic [DATA_W-1:0]     rd_data, fwd_data;
  logic [TAG_W-1:0]      rd_tag;
  logic                  rd_valid;
  logic                  cpu_live, line_hit, fill_line, early_hit;
  logic                  array_busy, hit_fire, miss_fire, fwd_fire;

  assign cpu_live   = cpu_req && !cpu_ack && !waiting;
  assign line_hit   = rd_valid && (rd_tag == req_tag);
  assign fill_line  = fill_active && (req_idx == fill_idx) && (req_tag == fill_tag);
  assign early_hit  = fill_line && filled[req_off];
  assign array_busy = mem_valid;
  assign hit_fire   = cpu_live && !array_busy && (line_hit || early_hit);
  assign miss_fire  = cpu_live && !line_hit && !fill_line && !fill_active;
  assign start_off  = wrap_mode ? req_off : '0;
  assign fwd_fire   = waiting && (fill_wrap ? first_beat : last_beat);
  // the owner keeps its address on the bus, so the array read port points at its word
  assign fwd_data   = (slot == req_off) ? mem_rdata : rd_data;

  refill_seq #(.LINE_WORDS(LINE_WORDS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (miss_fire),
    .start_off  (start_off),
    .word_in    (mem_valid),
    .active     (fill_active),
    .beat       (beat),
    .slot       (slot),
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .filled     (filled)
  );

  line_store #(
    .SETS(SETS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (req_idx),
    .rd_off   (req_off),
    .rd_data  (rd_data),
    .rd_tag   (rd_tag),
    .rd_valid (rd_valid),
    .wr_en    (beat),
    .wr_idx   (fill_idx),
    .wr_off   (slot),
    .wr_data  (mem_rdata),
    .clr_en   (miss_fire),
    .clr_idx  (req_idx),
    .set_en   (last_beat),
    .set_idx  (fill_idx),
    .set_tag  (fill_tag)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_line  <= '0;
      mem_off   <= '0;
      waiting   <= 1'b0;
      fill_wrap <= 1'b0;
      fill_idx  <= '0;
      fill_tag  <= '0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      mem_req <= miss_fire;
      cpu_ack <= hit_fire || fwd_fire;
      if (miss_fire) begin
        mem_line  <= {req_tag, req_idx};
        mem_off   <= start_off;
        fill_wrap <= wrap_mode;
        fill_idx  <= req_idx;
        fill_tag  <= req_tag;
        waiting   <= 1'b1;
      end else if (fwd_fire) begin
        waiting <= 1'b0;
      end
      if (fwd_fire)      cpu_rdata <= fwd_data;
      else if (hit_fire) cpu_rdata <= rd_data;
    end
  end

  // R3: a fetch request lasts one cycle
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R8: a new fetch is only issued once the previous fill has closed
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !$past(fill_active));

  // R6: an acknowledge not caused by forwarding never follows a refill-write edge
  p_refill_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !$past(fwd_fire)) |-> !$past(mem_valid));

  // R7: the stalled miss owner is never acknowledged while it waits
  p_owner_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !cpu_ack);

endmodule

// File: tb/crit_refill_test.sv
module crit_refill_test;
  localparam int ADDR_W = 10, DATA_W = 32, L = 4, SETS = 8;
  localparam int OFF_W = $clog2(L), IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W, LINE_W = ADDR_W - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0, wrap_mode = 1'b1, cpu_req = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic cpu_ack, mem_req, mem_valid = 1'b0;
  logic [DATA_W-1:0] cpu_rdata, mem_rdata = '0;
  logic [LINE_W-1:0] mem_line;
  logic [OFF_W-1:0] mem_off;

  always #10 clk = ~clk;  // 50 MHz

  crit_refill #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(L), .SETS(SETS)) uut (
    .clk(clk), .rst_n(rst_n), .wrap_mode(wrap_mode), .cpu_req(cpu_req),
    .cpu_addr(cpu_addr), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_line(mem_line), .mem_off(mem_off),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata));

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return (DATA_W'(a) * 32'h9E3779B1) ^ 32'hA5A50000;
  endfunction

  // ---------------- memory responder ----------------
  bit gap_mode = 0;
  bit rsp_busy = 0, prev_valid = 0;
  int rsp_k = 0, rsp_wait = 0, fill_words = 0, req_count = 0;
  logic [LINE_W-1:0] rsp_line, exp_line;
  logic [OFF_W-1:0]  rsp_off, exp_start;

  always @(negedge clk) begin
    prev_valid = mem_valid;
    if (rsp_busy && mem_valid) begin
      fill_words++;
      rsp_k++;
      if (rsp_k == L) rsp_busy = 0;
    end
    mem_valid = 1'b0;
    if (rst_n && mem_req) begin
      req_count++;
      check(!rsp_busy, "R8 request during fill", 32'(rsp_busy), 0);
      check(mem_line == exp_line, "R3 mem_line", 32'(mem_line), 32'(exp_line));
      check(mem_off == exp_start, "R3 mem_off", 32'(mem_off), 32'(exp_start));
      rsp_busy = 1; rsp_line = mem_line; rsp_off = mem_off;
      rsp_k = 0; fill_words = 0; rsp_wait = $urandom % 3;
    end else if (rsp_busy) begin
      if (rsp_wait > 0) rsp_wait--;
      else begin
        mem_valid = 1'b1;
        mem_rdata = mem_word({rsp_line, OFF_W'((32'(rsp_off) + rsp_k) % L)});
        if (gap_mode) rsp_wait = 1;
      end
    end
  end

  // ---------------- reference model of line presence ----------------
  logic [TAG_W-1:0] mtag [SETS];
  bit               mvalid [SETS];
  int last_lat = 0, last_fill = 0;
  bit last_hit = 0;

  task automatic cpu_read(input logic [ADDR_W-1:0] a);
    int lat = 0, r0;
    logic [IDX_W-1:0] ix = a[OFF_W +: IDX_W];
    logic [TAG_W-1:0] tg = a[ADDR_W-1 -: TAG_W];
    bit hit = mvalid[ix] && mtag[ix] == tg;
    exp_line  = a[ADDR_W-1:OFF_W];
    exp_start = wrap_mode ? a[OFF_W-1:0] : '0;
    r0 = req_count;
    @(negedge clk); #1;
    cpu_req = 1'b1; cpu_addr = a;
    do begin @(negedge clk); #1; lat++; end while (!cpu_ack && lat < 500);
    cpu_req = 1'b0;
    check(cpu_ack, hit ? "R2 ack missing" : "R4 ack missing", 32'(cpu_ack), 1);
    check(cpu_rdata == mem_word(a), hit ? "R2 hit data" : (wrap_mode ? "R4 forward data" : "R5 data"),
          cpu_rdata, mem_word(a));
    check((req_count - r0) == (hit ? 0 : 1), "R9 hit/miss vs line model", 32'(req_count - r0), hit ? 0 : 1);
    if (hit) check(!prev_valid, "R6 hit after refill-write edge", 32'(prev_valid), 0);
    else check(fill_words == (wrap_mode ? 1 : L), wrap_mode ? "R4 early release" : "R5 release after line",
               32'(fill_words), wrap_mode ? 1 : L);
    if (!hit) begin mtag[ix] = tg; mvalid[ix] = 1; end
    last_lat = lat; last_fill = fill_words; last_hit = hit;
  endtask

  task automatic drain();
    repeat (4 * L + 10) @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++) begin mvalid[s] = 0; mtag[s] = '0; end
    repeat (3) @(negedge clk);
    #1;
    check(!cpu_ack, "R1 ack after reset", 32'(cpu_ack), 0);
    check(!mem_req, "R1 mem_req after reset", 32'(mem_req), 0);
    rst_n = 1'b1;

    // R1 / R4: first access misses; wrap order, release on first word
    wrap_mode = 1; gap_mode = 0;
    cpu_read(10'h012);
    check(!last_hit, "R1 first read misses", 32'(last_hit), 0);
    drain();
    // R2: quiet hit answered after one edge
    cpu_read(10'h013);
    check(last_lat == 1, "R2 hit latency", 32'(last_lat), 1);

    // R6: hit to another line while a fill streams back to back
    cpu_read(10'h020);
    cpu_read(10'h011);
    check(last_fill == L, "R6 hit waits out refill writes", 32'(last_fill), L);
    drain();

    // R7: early hit on a written word, wait on an unwritten one (gapped fill)
    gap_mode = 1;
    cpu_read(10'h045);            // order 1,2,3,0
    cpu_read(10'h046);            // slot 2 lands second
    check(last_fill < L, "R7 early hit inside fill", 32'(last_fill), L - 1);
    cpu_read(10'h044);            // slot 0 lands last
    check(last_fill == L, "R7 unwritten word waits", 32'(last_fill), L);
    drain();

    // R8: second miss issued only after the current fill closes
    cpu_read(10'h061);
    cpu_read(10'h0A3);
    drain();
    gap_mode = 0;

    // R5: line ordering, offsets 2, 3 (last slot) and 0
    wrap_mode = 0;
    cpu_read(10'h10A);
    drain();
    cpu_read(10'h14F);
    drain();
    cpu_read(10'h190);
    drain();

    // R9: conflict in one set overwrites, re-read misses
    wrap_mode = 1;
    cpu_read(10'h078);
    drain();
    cpu_read(10'h078 + SETS * L);
    drain();
    cpu_read(10'h079);
    check(!last_hit, "R9 evicted line misses again", 32'(last_hit), 0);
    drain();
    cpu_read(10'h07B);
    check(last_hit && last_lat == 1, "R9 refilled line hits", 32'(last_lat), 1);

    // constrained random mix
    for (int i = 0; i < 240; i++) begin
      if (i % 60 == 0) begin
        drain();
        wrap_mode = 1'($urandom % 2);
        gap_mode  = 1'($urandom % 2);
      end
      cpu_read(ADDR_W'($urandom % (SETS * L * 3)));
    end
    drain();
    check(!rsp_busy, "R8 all fills closed", 32'(rsp_busy), 0);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule